// File: doc/BRIEF.md
# NAND Page ECC Generator

This block computes a 24-bit Hamming-style check code over NAND page data while the data phase streams past it. Each 512-byte sub-block of the page gets its own code. A page holds one to four sub-blocks, which covers pages of up to 2048 bytes. Data arrives one beat at a time, either a byte or a little-endian word, chosen by a parameter. A pulse on `pg_start` opens a page and clears every earlier result. The page then closes on one of two events: a beat flagged as the last transfer, or the end of the configured number of sub-blocks.

Each finished sub-block lands in its own 32-bit result word. Bits [11:0] hold the odd-parity field, bits [23:12] hold the even-parity field, and the top byte is a status byte whose bit 6 marks the code as valid. A controller compares these codes with the stored ones to locate single-bit errors. For a single flipped bit, the XOR of the odd fields is the bit's position and the XOR of the even fields is the complement of that position. `busy` stays high from the opening of a page until its final code has been written.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset `busy` is 0 and every result word reads zero.
- R2: Bit k of the odd field (result bits [11:0]) is the XOR of all data bits of the sub-block whose 12-bit position has bit k set. A bit's position is its byte offset within the sub-block times 8 plus its bit index. In a word beat, byte lane j (bits 8j+7..8j) is at byte offset 4·beat+j.
- R3: Bit k of the even field (result bits [23:12]) is the XOR of the data bits whose position has bit k clear.
- R4: Result word i (bits 32i+31..32i of `ecc_words`) holds sub-block i. Once the code is written its status byte [31:24] is 0x40. A sub-block that has not been finished reads as all zero.
- R5: A sub-block closes after 512 bytes, and the next accepted beat starts the next sub-block at offset 0.
- R6: A beat with `dat_last` set closes the current sub-block, even when it is partial, and ends the page. A last beat that falls exactly on a sub-block boundary produces no extra result.
- R7: `cfg_chunks` (number of sub-blocks minus one) is sampled with `pg_start`. The page ends after that many sub-blocks even when no last flag arrives.
- R8: `busy` is 1 from the clock edge after `pg_start`. It falls at the edge that writes the final code, which is one edge after the page's final beat is accepted, and that code is visible in the same cycle.
- R9: `pg_start` clears all result words and aborts any page in progress. This includes a final code that would be written at that same edge. A beat presented together with `pg_start` is the first beat of the new page.
- R10: Beats presented while no page is open change neither the result words nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_start | input | 1 | Opens a new page and clears the results |
| cfg_chunks | input | 2 | Sub-blocks in the page minus one, sampled with `pg_start` |
| dat_vld | input | 1 | Data beat strobe |
| dat | input | DATA_W (32) | Beat data, byte lane 0 first |
| dat_last | input | 1 | Marks the final beat of the page |
| ecc_words | output | 128 | Four result words, word i at bits 32i+31..32i |
| busy | output | 1 | Page computation not yet complete |

## Verification
Two pairs of events can fall on the same clock edge. In the first pair, a last flag arrives on the 512th byte of a sub-block, so the boundary close and the last-transfer close coincide. The bench sends pages whose last beat is exactly at 128 and 512 beats and checks that no further word turns valid. In the second pair, `pg_start` is raised in the cycle right after a page's last beat, so the abort meets the pending final write. The bench then expects every word to read zero with `busy` high. A start coincident with the first data beat is also swept, and the results are compared against codes the bench derives bit by bit from the positions of the set bits.

// File: rtl/pgecc_pkg.sv
package pgecc_pkg;
   localparam int FIELD_W = 12;
   localparam int CODE_W  = 2 * FIELD_W;
   localparam int WORD_W  = 32;
   localparam logic [WORD_W-CODE_W-1:0] ST_VALID = 8'h40;

   typedef struct packed {
      logic [FIELD_W-1:0] even;
      logic [FIELD_W-1:0] odd;
   } code_t;

   function automatic logic [WORD_W-1:0] pack_word(code_t c);
      return {ST_VALID, c};
   endfunction
endpackage

// File: rtl/pgecc_beat_parity.sv
module pgecc_beat_parity
   import pgecc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = 12,
   localparam int LOGW  = $clog2(DATA_W),
   localparam int BW    = POS_W - LOGW
)(
   input  logic [DATA_W-1:0] dat,
   input  logic [BW-1:0]     beat_idx,
   output code_t             contrib
);
   function automatic logic [DATA_W-1:0] lane_mask(int k);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_W; b++) m[b] = b[k];
      return m;
   endfunction

   logic par_all;
   assign par_all = ^dat;

   for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
      if (k < LOGW) begin : g_in_beat
         localparam logic [DATA_W-1:0] MASK = lane_mask(k);
         assign contrib.odd[k]  = ^(dat & MASK);
         assign contrib.even[k] = ^(dat & ~MASK);
      end else if (k < POS_W) begin : g_beat_pos
         assign contrib.odd[k]  = par_all &  beat_idx[k-LOGW];
         assign contrib.even[k] = par_all & ~beat_idx[k-LOGW];
      end else begin : g_unused
         assign contrib.odd[k]  = 1'b0;
         assign contrib.even[k] = 1'b0;
      end
   end
endmodule

// File: rtl/pgecc_seq.sv
module pgecc_seq #(
   parameter int BEATS      = 128,
   parameter int MAX_CHUNKS = 4,
   localparam int BW = $clog2(BEATS),
   localparam int CW = $clog2(MAX_CHUNKS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pg_start,
   input  logic [CW-1:0] cfg_chunks,
   input  logic          dat_vld,
   input  logic          dat_last,
   output logic          take,
   output logic [BW-1:0] beat_idx,
   output logic [CW-1:0] chunk_idx,
   output logic          close,
   output logic          page_end
);
   logic          open_q;
   logic [BW-1:0] beat_q;
   logic [CW-1:0] chunk_q, limit_q, cur_limit;
   logic          eff_open, at_edge;

   assign eff_open  = pg_start | open_q;
   assign beat_idx  = pg_start ? '0 : beat_q;
   assign chunk_idx = pg_start ? '0 : chunk_q;
   assign cur_limit = pg_start ? cfg_chunks : limit_q;
   assign take      = dat_vld & eff_open;
   assign at_edge   = (beat_idx == BW'(BEATS - 1));
   assign close     = take & (dat_last | at_edge);
   assign page_end  = take & (dat_last | (at_edge & (chunk_idx == cur_limit)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         beat_q  <= '0;
         chunk_q <= '0;
         limit_q <= '0;
      end else begin
         open_q  <= eff_open & ~page_end;
         limit_q <= cur_limit;
         if (take) begin
            beat_q  <= close ? '0 : beat_idx + 1'b1;
            chunk_q <= close ? chunk_idx + 1'b1 : chunk_idx;
         end else begin
            beat_q  <= beat_idx;
            chunk_q <= chunk_idx;
         end
      end
   end
endmodule

// File: rtl/pgecc_bank.sv
module pgecc_bank
   import pgecc_pkg::*;
#(
   parameter int MAX_CHUNKS = 4,
   localparam int CW = $clog2(MAX_CHUNKS)
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pg_start,
   input  logic                         s1_vld,
   input  code_t                        s1_code,
   input  logic [CW-1:0]                s1_chunk,
   input  logic                         s1_close,
   input  logic                         s1_end,
   output logic [MAX_CHUNKS*WORD_W-1:0] ecc_words,
   output logic                         busy
);
   code_t acc_q, acc_nxt;
   logic  busy_q;

   assign acc_nxt = acc_q ^ s1_code;
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         busy_q <= 1'b0;
      end else if (pg_start) begin
         acc_q  <= '0;
         busy_q <= 1'b1;
      end else if (s1_vld) begin
         acc_q <= s1_close ? '0 : acc_nxt;
         if (s1_end) busy_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < MAX_CHUNKS; i++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (pg_start)
            slot_q <= '0;
         else if (s1_vld && s1_close && (s1_chunk == CW'(i)))
            slot_q <= pack_word(acc_nxt);
      end
      assign ecc_words[i*WORD_W +: WORD_W] = slot_q;
   end
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
   import pgecc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CHUNK_BYTES = 512,
   parameter int MAX_CHUNKS  = 4,
   localparam int CW = $clog2(MAX_CHUNKS)
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pg_start,
   input  logic [CW-1:0]                cfg_chunks,
   input  logic                         dat_vld,
   input  logic [DATA_W-1:0]            dat,
   input  logic                         dat_last,
   output logic [MAX_CHUNKS*WORD_W-1:0] ecc_words,
   output logic                         busy
);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BEATS      = CHUNK_BYTES / BEAT_BYTES;
   localparam int POS_W      = $clog2(CHUNK_BYTES * 8);
   localparam int BW         = $clog2(BEATS);

   if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 8, 16 or 32");
   end
   if (CHUNK_BYTES > 512 || (1 << $clog2(CHUNK_BYTES)) != CHUNK_BYTES
       || CHUNK_BYTES <= BEAT_BYTES) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two above one beat and at most 512");
   end
   if (MAX_CHUNKS < 2 || (1 << CW) != MAX_CHUNKS) begin : g_bad_count
      $error("MAX_CHUNKS must be a power of two of at least 2");
   end

   logic          take, close, page_end;
   logic [BW-1:0] beat_idx;
   logic [CW-1:0] chunk_idx;
   code_t         contrib;

   pgecc_seq #(.BEATS(BEATS), .MAX_CHUNKS(MAX_CHUNKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .pg_start(pg_start), .cfg_chunks(cfg_chunks),
      .dat_vld(dat_vld), .dat_last(dat_last), .take(take), .beat_idx(beat_idx),
      .chunk_idx(chunk_idx), .close(close), .page_end(page_end)
   );

   pgecc_beat_parity #(.DATA_W(DATA_W), .POS_W(POS_W)) u_par (
      .dat(dat), .beat_idx(beat_idx), .contrib(contrib)
   );

   logic          s1_vld, s1_close, s1_end;
   code_t         s1_code;
   logic [CW-1:0] s1_chunk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         s1_code  <= '0;
         s1_chunk <= '0;
         s1_close <= 1'b0;
         s1_end   <= 1'b0;
      end else begin
         s1_vld <= take;
         if (take) begin
            s1_code  <= contrib;
            s1_chunk <= chunk_idx;
            s1_close <= close;
            s1_end   <= page_end;
         end
      end
   end

   pgecc_bank #(.MAX_CHUNKS(MAX_CHUNKS)) u_bank (
      .clk(clk), .rst_n(rst_n), .pg_start(pg_start), .s1_vld(s1_vld),
      .s1_code(s1_code), .s1_chunk(s1_chunk), .s1_close(s1_close),
      .s1_end(s1_end), .ecc_words(ecc_words), .busy(busy)
   );
endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk #(
   parameter int MAX_CHUNKS = 4
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       pg_start,
   input logic                       busy,
   input logic [MAX_CHUNKS*32-1:0]   ecc_words
);
   logic [MAX_CHUNKS-1:0] valids;
   logic                  status_ok;

   always_comb begin
      status_ok = 1'b1;
      for (int i = 0; i < MAX_CHUNKS; i++) begin
         valids[i] = ecc_words[i*32 + 30];
         if (ecc_words[i*32+24 +: 8] != 8'h00 && ecc_words[i*32+24 +: 8] != 8'h40)
            status_ok = 1'b0;
         if (ecc_words[i*32+24 +: 8] == 8'h00 && ecc_words[i*32 +: 24] != 24'h0)
            status_ok = 1'b0;
      end
   end

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      pg_start |=> busy); // R8
   AST_DONE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> valids[0]); // R8
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pg_start |=> (ecc_words == '0)); // R9
   AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      status_ok); // R4
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !pg_start) |=> ($stable(ecc_words) && !busy)); // R10
   AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(valids) & ~valids) != '0) |-> $past(pg_start)); // R9
endmodule

bind nand_page_ecc nand_page_ecc_chk #(.MAX_CHUNKS(MAX_CHUNKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pg_start(pg_start), .busy(busy), .ecc_words(ecc_words)
);

// File: tb/nand_page_ecc_tb.sv
module nand_page_ecc_tb;
   localparam int BEATS = 128;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pg_start = 1'b0;
   logic [1:0]   cfg_chunks = '0;
   logic         dat_vld = 1'b0;
   logic [31:0]  dat = '0;
   logic         dat_last = 1'b0;
   logic [127:0] ecc_words;
   logic         busy;

   int n_run = 0, n_fail = 0;
   logic [31:0] exp_w [4];

   always #10 clk = ~clk;

   nand_page_ecc u_dut (
      .clk(clk), .rst_n(rst_n), .pg_start(pg_start), .cfg_chunks(cfg_chunks),
      .dat_vld(dat_vld), .dat(dat), .dat_last(dat_last),
      .ecc_words(ecc_words), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
      end
   endtask

   task automatic chk_words(input string tag);
      for (int i = 0; i < 4; i++)
         chk(ecc_words[i*32 +: 32] === exp_w[i], tag, ecc_words[i*32 +: 32], exp_w[i]);
   endtask

   function automatic logic [31:0] pat(int seed, int beat, int flip);
      logic [31:0] v;
      if (seed == 0) v = '0;
      else if (seed == 1) v = '1;
      else v = (beat * 32'h9E3779B1) ^ (seed * 32'h7F4A7C15) ^ (32'(beat) << (seed % 7));
      if (flip >= 0 && flip / 32 == beat) v ^= (32'h1 << (flip % 32));
      return v;
   endfunction

   // Reference model: odd = XOR of set-bit positions, even = XOR of their complements
   task automatic model(input int cfg, input int nbeats, input bit use_last, input int seed,
                        input int flip, output bit ended, output bit by_final);
      int lim, eff, nvalid;
      logic [11:0] odd, even;
      lim = (cfg + 1) * BEATS;
      eff = (nbeats < lim) ? nbeats : lim;
      ended = use_last || (nbeats >= lim);
      by_final = ended && (eff == nbeats);
      nvalid = ended ? (eff + BEATS - 1) / BEATS : eff / BEATS;
      for (int c = 0; c < 4; c++) begin
         odd = '0; even = '0;
         for (int g = c * 512; g < (c + 1) * 512 && g < eff * 4; g++) begin
            logic [31:0] w;
            w = pat(seed, g / 4, flip);
            for (int b = 0; b < 8; b++)
               if (w[(g % 4) * 8 + b]) begin
                  odd  ^= 12'((g % 512) * 8 + b);
                  even ^= ~12'((g % 512) * 8 + b);
               end
         end
         exp_w[c] = (c < nvalid) ? {8'h40, even, odd} : 32'h0;
      end
   endtask

   task automatic send_page(input int cfg, input int nbeats, input bit use_last, input int seed,
                            input int flip, input bit merge, input string tag);
      bit ended, by_final;
      int first;
      @(negedge clk);
      pg_start = 1'b1;
      cfg_chunks = 2'(cfg);
      first = 0;
      if (merge) begin
         dat_vld = 1'b1;
         dat = pat(seed, 0, flip);
         dat_last = use_last && (nbeats == 1);
         first = 1;
      end
      @(negedge clk);
      pg_start = 1'b0;
      chk(busy === 1'b1, {tag, " R8 busy after start"}, 32'(busy), 32'h1);
      for (int bt = first; bt < nbeats; bt++) begin
         dat_vld = 1'b1;
         dat = pat(seed, bt, flip);
         dat_last = use_last && (bt == nbeats - 1);
         @(negedge clk);
      end
      dat_vld = 1'b0;
      dat_last = 1'b0;
      model(cfg, nbeats, use_last, seed, flip, ended, by_final);
      if (by_final) begin
         chk(busy === 1'b1, {tag, " R8 busy one cycle past final beat"}, 32'(busy), 32'h1);
         @(negedge clk);
      end
      chk(busy === !ended, {tag, " R8 busy level at end"}, 32'(busy), 32'(!ended));
      chk_words(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) exp_w[i] = '0;
      chk(busy === 1'b0, "R1 busy after reset", 32'(busy), 32'h0);
      chk_words("R1 reset words");

      // R10: beats with no page open
      for (int i = 0; i < 5; i++) begin
         dat_vld = 1'b1; dat = 32'hA5A5_0000 + 32'(i); dat_last = (i == 4);
         @(negedge clk);
      end
      dat_vld = 1'b0; dat_last = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0, "R10 idle beats busy", 32'(busy), 32'h0);
      chk_words("R10 idle beats words");

      // R2 R3 single-bit position at byte 300 bit 5
      send_page(0, 128, 1'b0, 0, 2405, 1'b0, "R2 R3 single bit");
      chk(ecc_words[31:0] === 32'h4069A965, "R2 R3 explicit code", ecc_words[31:0], 32'h4069A965);
      // single bit in sub-block 1, position 100
      send_page(1, 256, 1'b0, 0, 4096 + 100, 1'b0, "R5 single bit chunk1");
      chk(ecc_words[63:32] === 32'h40F9B064, "R5 R4 explicit code word1", ecc_words[63:32], 32'h40F9B064);

      // R7 R4 sweep over sizes, ended by count or by an early last flag
      for (int cfg = 0; cfg < 4; cfg++)
         for (int mode = 0; mode < 2; mode++)
            send_page(cfg, (cfg + 1) * BEATS - mode * 37, 1'(mode), cfg * 5 + mode + 3, -1,
                      1'(cfg % 2), "R7 R6 R2 R3 sweep");

      send_page(3, 512, 1'b0, 0, -1, 1'b0, "R4 zeros");
      send_page(3, 512, 1'b1, 1, -1, 1'b0, "R6 ones last on full page");
      send_page(3, 128, 1'b1, 21, -1, 1'b0, "R6 last on boundary");
      send_page(3, 200, 1'b1, 11, -1, 1'b0, "R6 partial");
      send_page(1, 300, 1'b0, 9, -1, 1'b0, "R10 beats after count end");
      send_page(2, 1, 1'b1, 13, -1, 1'b1, "R9 merged single beat");

      // R9 restart mid-page
      send_page(3, 130, 1'b0, 17, -1, 1'b0, "R9 open page");
      @(negedge clk);
      pg_start = 1'b1; cfg_chunks = 2'd0;
      @(negedge clk);
      pg_start = 1'b0;
      for (int i = 0; i < 4; i++) exp_w[i] = '0;
      chk(busy === 1'b1, "R9 busy after restart", 32'(busy), 32'h1);
      chk_words("R9 restart clears");

      // R9 start in the cycle after a final beat (pending write aborted)
      @(negedge clk);
      pg_start = 1'b1; cfg_chunks = 2'd0;
      @(negedge clk);
      pg_start = 1'b0;
      for (int bt = 0; bt < 10; bt++) begin
         dat_vld = 1'b1; dat = pat(19, bt, -1); dat_last = (bt == 9);
         @(negedge clk);
      end
      dat_vld = 1'b0; dat_last = 1'b0;
      pg_start = 1'b1;
      @(negedge clk);
      pg_start = 1'b0;
      chk(busy === 1'b1, "R9 collide busy", 32'(busy), 32'h1);
      chk_words("R9 collide clears pending");
      send_page(0, 60, 1'b1, 23, -1, 1'b0, "R9 after collide");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule